// File: doc/BRIEF.md
# Chained Descriptor DMA Engine

This block moves bytes between system memory and a byte-wide peripheral stream. It follows a linked list of descriptors that software places in memory. Each descriptor takes four 32-bit words. The first word holds the flags, the second the buffer address, the third the address of the next descriptor, and the fourth is not used. The flags word gives the byte count in its low 16 bits. Bit 30 must be set for the descriptor to be valid. Bit 31 marks the last descriptor of the chain.

Software sets up the chain in three steps:
- It writes the address of the first descriptor.
- It sets the enable bit.
- It writes the run bit together with the direction.

The engine then fetches each descriptor and moves its bytes one at a time. For each byte it either reads memory and sends the byte on the transmit stream, or takes the byte from the receive stream and writes it to memory. When the chain ends, or when something goes wrong, the engine drops run. It then writes a 4-bit outcome code and sets the interrupt status bit.

The memory port is a simple request/acknowledge port with byte enables. Only one access is outstanding at any time.

Top module: `dma_chain_engine`

## Requirements
- R1: After reset, every register reads zero and irq is low. The register indexes are: control 0, interrupt enable 1, interrupt status 2, descriptor pointer 3, channel control 4.
- R2: Control bit 0 (enable) reads back the value last written to it. Writing 1 to control bit 8 does four things: it stops any chain at once, makes the run bit read 0, clears the event field, and clears the interrupt status bit. Bit 8 itself always reads 0.
- R3: A chain starts at the descriptor pointer. The engine fetches the flags word at offset 0, the buffer address at offset 4 and the next-descriptor address at offset 8. It follows the next-descriptor field and stops after the descriptor whose flags bit 31 is set. Flags bits 15:0 give the number of bytes to move.
- R4: With channel control bit 22 = 0, the engine reads each descriptor's bytes from its buffer address upward. It sends them on txData in that order, one per cycle with txValid and txReady both high.
- R5: With channel control bit 22 = 1, the engine writes each byte taken on a cycle with rxValid and rxReady both high to the next higher buffer address. The write uses a word-aligned memAddr, and memBe has only the lane bit for address bits 1:0 set. Neighbouring bytes are left unchanged.
- R6: When the last descriptor completes, channel control bit 7 (run) reads 0, bits 3:0 (event) read 15, and interrupt status bit 0 is set.
- R7: irq is high exactly when interrupt status bit 0 and interrupt enable bit 0 are both 1. Writing 1 to status bit 0 clears it, and writing 0 leaves it unchanged.
- R8: A descriptor whose flags bit 30 is clear ends the chain with event 3, and no byte is moved.
- R9: An error answer (memErr) to a descriptor fetch ends the chain with event 3. An error answer to a data access ends it with event 4. In both cases run reads 0 and status bit 0 is set.
- R10: perEnd seen while a chain is active ends it with event 5 and sets status bit 0.
- R11: A write to channel control while run reads 1 has no effect, and this includes the direction bit. A write while idle loads the direction bit and clears the event field to 0.
- R12: Writing run while enable is 0 starts nothing.
- R13: A descriptor with a byte count of 0 moves no data, and the chain goes on to its next descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfgWrEn | input | 1 | Register write strobe |
| cfgAddr | input | 3 | Register index |
| cfgWrData | input | 32 | Register write data |
| cfgRdData | output | 32 | Register read data for cfgAddr (combinational) |
| irq | output | 1 | Interrupt request |
| memReq | output | 1 | Memory access request, held until memAck |
| memWe | output | 1 | Memory access is a write |
| memAddr | output | 32 | Byte address; word-aligned for data accesses |
| memBe | output | 4 | Byte-lane enables |
| memWdata | output | 32 | Write data (the byte repeated in each lane) |
| memRdata | input | 32 | Read data, valid with memAck |
| memAck | input | 1 | Access complete |
| memErr | input | 1 | Access failed, valid with memAck |
| txValid | output | 1 | Transmit byte valid |
| txData | output | 8 | Transmit byte |
| txReady | input | 1 | Peripheral accepts the transmit byte |
| rxValid | input | 1 | Receive byte valid |
| rxData | input | 8 | Receive byte |
| rxReady | output | 1 | Engine accepts a receive byte |
| perEnd | input | 1 | Peripheral signals end of transfer |

## Verification
The assertions rely on a well-behaved memory. It answers each request with a single memAck pulse and asserts memErr only together with memAck. Its answer does not come in the same cycle as the request. The bench memory model meets this: it registers the request and acknowledges it one cycle later. It returns an error only for addresses with bit 31 set. perEnd and soft reset are treated as aborts, so the request-hold and transmit-hold properties exclude the cycles in which either occurs. The bench pulses perEnd only while a receive chain is waiting for data, and it writes soft reset only while the transmit side is stalled.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;

  localparam int REG_W = 32;

  // register indexes on the configuration port
  localparam logic [2:0] IDX_CTRL  = 3'd0;
  localparam logic [2:0] IDX_IEN   = 3'd1;
  localparam logic [2:0] IDX_ISTS  = 3'd2;
  localparam logic [2:0] IDX_DESC  = 3'd3;
  localparam logic [2:0] IDX_CHAN  = 3'd4;

  // bit positions that software and descriptors rely on
  localparam int BIT_ENABLE = 0;
  localparam int BIT_SRST   = 8;
  localparam int BIT_RUN    = 7;
  localparam int BIT_DIR    = 22;
  localparam int BIT_FMT    = 30;
  localparam int BIT_LAST   = 31;

  typedef enum logic [3:0] {
    EV_NONE      = 4'd0,
    EV_UNDER     = 4'd1,
    EV_OVER      = 4'd2,
    EV_DESC_ERR  = 4'd3,
    EV_DATA_ERR  = 4'd4,
    EV_EARLY_END = 4'd5,
    EV_SUCCESS   = 4'd15
  } evCode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic startChain;
    logic loadFlags;
    logic loadBuf;
    logic loadBranch;
    logic loadByte;
    logic stepByte;
    logic followBranch;
  } dpStrobe_t;

endpackage

// File: rtl/dma_regs.sv
module dma_regs
  import dma_chain_pkg::*;
#(
  parameter int AddrW = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cfgWrEn,
  input  logic [2:0]            cfgAddr,
  input  logic [REG_W-1:0]      cfgWrData,
  output logic [REG_W-1:0]      cfgRdData,
  input  logic                  busy,
  input  logic                  doneStrobe,
  input  logic [3:0]            doneCode,
  output logic                  startPulse,
  output logic                  softRst,
  output logic                  dirP2M,
  output logic [AddrW-1:0]      descPtr,
  output logic                  irqOut
);

  logic             enableQ, irqEnQ, irqStsQ, dirQ;
  logic [3:0]       eventQ;
  logic [AddrW-1:0] descPtrQ;
  logic             wrCtrl, wrIen, wrSts, wrDesc, wrChan;
  logic             unusedWrBits;

  assign wrCtrl = cfgWrEn && (cfgAddr == IDX_CTRL);
  assign wrIen  = cfgWrEn && (cfgAddr == IDX_IEN);
  assign wrSts  = cfgWrEn && (cfgAddr == IDX_ISTS);
  assign wrDesc = cfgWrEn && (cfgAddr == IDX_DESC);
  assign wrChan = cfgWrEn && (cfgAddr == IDX_CHAN);

  assign softRst    = wrCtrl && cfgWrData[BIT_SRST];
  assign startPulse = wrChan && cfgWrData[BIT_RUN] && enableQ && !busy && !softRst;
  assign unusedWrBits = ^cfgWrData;

  always_ff @(posedge clk) begin
    if (rst) begin
      enableQ  <= 1'b0;
      irqEnQ   <= 1'b0;
      irqStsQ  <= 1'b0;
      dirQ     <= 1'b0;
      eventQ   <= EV_NONE;
      descPtrQ <= '0;
    end else begin
      if (wrCtrl) enableQ  <= cfgWrData[BIT_ENABLE];
      if (wrIen)  irqEnQ   <= cfgWrData[0];
      if (wrDesc) descPtrQ <= cfgWrData[AddrW-1:0];
      if (softRst) begin
        irqStsQ <= 1'b0;
        eventQ  <= EV_NONE;
      end else begin
        if (doneStrobe) begin
          irqStsQ <= 1'b1;
          eventQ  <= doneCode;
        end else if (wrSts && cfgWrData[0]) begin
          irqStsQ <= 1'b0;
        end
        if (wrChan && !busy) begin
          dirQ   <= cfgWrData[BIT_DIR];
          eventQ <= EV_NONE;
        end
      end
    end
  end

  always_comb begin
    cfgRdData = '0;
    unique case (cfgAddr)
      IDX_CTRL: cfgRdData[BIT_ENABLE] = enableQ;
      IDX_IEN:  cfgRdData[0] = irqEnQ;
      IDX_ISTS: cfgRdData[0] = irqStsQ;
      IDX_DESC: cfgRdData[AddrW-1:0] = descPtrQ;
      IDX_CHAN: begin
        cfgRdData[BIT_DIR] = dirQ;
        cfgRdData[BIT_RUN] = busy;
        cfgRdData[3:0]     = eventQ;
      end
      default: cfgRdData = '0;
    endcase
  end

  assign dirP2M  = dirQ;
  assign descPtr = descPtrQ;
  assign irqOut  = irqStsQ & irqEnQ;

  // R6: a completion always leaves the status bit set
  a_r6_done_sets_status: assert property (@(posedge clk) disable iff (rst)
    (doneStrobe && !softRst) |=> irqStsQ);

  // R12: a chain only begins while enabled
  a_r12_start_needs_enable: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> enableQ);

  // R11: direction cannot move under an active chain
  a_r11_dir_frozen: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(dirQ));

endmodule

// File: rtl/dma_datapath.sv
module dma_datapath
  import dma_chain_pkg::*;
#(
  parameter int AddrW  = 32,
  parameter int CountW = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  dpStrobe_t         st,
  input  logic              dirP2M,
  input  logic [AddrW-1:0]  descPtr,
  input  logic [REG_W-1:0]  memRdata,
  input  logic [7:0]        rxData,
  output logic              fmtOk,
  output logic              lastDesc,
  output logic              countZero,
  output logic              remainOne,
  output logic [AddrW-1:0]  curDesc,
  output logic [AddrW-1:0]  bufAddr,
  output logic [7:0]        byteLatch
);

  localparam int Lanes = REG_W / 8;
  localparam int LaneW = $clog2(Lanes);

  logic [AddrW-1:0]  curDescQ, bufQ, branchQ;
  logic [CountW-1:0] remainQ;
  logic              fmtQ, lastQ;
  logic [7:0]        byteQ, byteIn;
  logic [7:0]        lane [Lanes];
  logic              unusedFlagBits;

  for (genvar g = 0; g < Lanes; g++) begin : g_lane
    assign lane[g] = memRdata[8*g +: 8];
  end

  assign byteIn = dirP2M ? rxData : lane[bufQ[LaneW-1:0]];
  assign unusedFlagBits = ^memRdata[BIT_FMT-1:CountW];

  always_ff @(posedge clk) begin
    if (rst) begin
      curDescQ <= '0;
      bufQ     <= '0;
      branchQ  <= '0;
      remainQ  <= '0;
      fmtQ     <= 1'b0;
      lastQ    <= 1'b0;
      byteQ    <= '0;
    end else begin
      if (st.startChain)   curDescQ <= descPtr;
      if (st.followBranch) curDescQ <= branchQ;
      if (st.loadFlags) begin
        remainQ <= memRdata[CountW-1:0];
        fmtQ    <= memRdata[BIT_FMT];
        lastQ   <= memRdata[BIT_LAST];
      end
      if (st.loadBuf)    bufQ    <= memRdata[AddrW-1:0];
      if (st.loadBranch) branchQ <= memRdata[AddrW-1:0];
      if (st.loadByte)   byteQ   <= byteIn;
      if (st.stepByte) begin
        bufQ    <= bufQ + AddrW'(1);
        remainQ <= remainQ - CountW'(1);
      end
    end
  end

  assign fmtOk     = fmtQ;
  assign lastDesc  = lastQ;
  assign countZero = (remainQ == '0);
  assign remainOne = (remainQ == CountW'(1));
  assign curDesc   = curDescQ;
  assign bufAddr   = bufQ;
  assign byteLatch = byteQ;

endmodule

// File: rtl/dma_ctrl.sv
module dma_ctrl
  import dma_chain_pkg::*;
#(
  parameter int AddrW = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              softRst,
  input  logic              startPulse,
  input  logic              dirP2M,
  input  logic              memAck,
  input  logic              memErr,
  input  logic              txReady,
  input  logic              rxValid,
  input  logic              perEnd,
  input  logic              fmtOk,
  input  logic              lastDesc,
  input  logic              countZero,
  input  logic              remainOne,
  input  logic [AddrW-1:0]  curDesc,
  input  logic [AddrW-1:0]  bufAddr,
  input  logic [7:0]        byteLatch,
  output logic              busy,
  output logic              doneStrobe,
  output logic [3:0]        doneCode,
  output dpStrobe_t         st,
  output logic              memReq,
  output logic              memWe,
  output logic [AddrW-1:0]  memAddr,
  output logic [3:0]        memBe,
  output logic [REG_W-1:0]  memWdata,
  output logic              txValid,
  output logic [7:0]        txData,
  output logic              rxReady
);

  typedef enum logic [3:0] {
    S_IDLE, S_FLAGS, S_BUF, S_BRANCH, S_RD, S_TX, S_RX, S_WR, S_NEXT
  } state_e;

  state_e stateQ, stateD;
  logic [AddrW-1:0] wordAddr;

  assign wordAddr = {bufAddr[AddrW-1:2], 2'b00};
  assign busy     = (stateQ != S_IDLE);

  always_comb begin
    stateD     = stateQ;
    st         = '0;
    doneStrobe = 1'b0;
    doneCode   = EV_NONE;
    memReq     = 1'b0;
    memWe      = 1'b0;
    memAddr    = curDesc;
    memBe      = 4'hF;
    memWdata   = {4{byteLatch}};
    txValid    = 1'b0;
    txData     = byteLatch;
    rxReady    = 1'b0;

    unique case (stateQ)
      S_IDLE: if (startPulse) begin
        st.startChain = 1'b1;
        stateD = S_FLAGS;
      end
      S_FLAGS: begin
        memReq = 1'b1;
        if (memAck) begin
          if (memErr) begin
            doneStrobe = 1'b1; doneCode = EV_DESC_ERR; stateD = S_IDLE;
          end else begin
            st.loadFlags = 1'b1; stateD = S_BUF;
          end
        end
      end
      S_BUF: begin
        if (!fmtOk) begin
          doneStrobe = 1'b1; doneCode = EV_DESC_ERR; stateD = S_IDLE;
        end else begin
          memReq  = 1'b1;
          memAddr = curDesc + AddrW'(4);
          if (memAck) begin
            if (memErr) begin
              doneStrobe = 1'b1; doneCode = EV_DESC_ERR; stateD = S_IDLE;
            end else begin
              st.loadBuf = 1'b1; stateD = S_BRANCH;
            end
          end
        end
      end
      S_BRANCH: begin
        memReq  = 1'b1;
        memAddr = curDesc + AddrW'(8);
        if (memAck) begin
          if (memErr) begin
            doneStrobe = 1'b1; doneCode = EV_DESC_ERR; stateD = S_IDLE;
          end else begin
            st.loadBranch = 1'b1;
            if (countZero)   stateD = S_NEXT;
            else if (dirP2M) stateD = S_RX;
            else             stateD = S_RD;
          end
        end
      end
      S_RD: begin
        memReq  = 1'b1;
        memAddr = wordAddr;
        if (memAck) begin
          if (memErr) begin
            doneStrobe = 1'b1; doneCode = EV_DATA_ERR; stateD = S_IDLE;
          end else begin
            st.loadByte = 1'b1; stateD = S_TX;
          end
        end
      end
      S_TX: begin
        txValid = 1'b1;
        if (txReady) begin
          st.stepByte = 1'b1;
          stateD = remainOne ? S_NEXT : S_RD;
        end
      end
      S_RX: begin
        rxReady = 1'b1;
        if (rxValid) begin
          st.loadByte = 1'b1; stateD = S_WR;
        end
      end
      S_WR: begin
        memReq  = 1'b1;
        memWe   = 1'b1;
        memAddr = wordAddr;
        memBe   = 4'b0001 << bufAddr[1:0];
        if (memAck) begin
          if (memErr) begin
            doneStrobe = 1'b1; doneCode = EV_DATA_ERR; stateD = S_IDLE;
          end else begin
            st.stepByte = 1'b1;
            stateD = remainOne ? S_NEXT : S_RX;
          end
        end
      end
      S_NEXT: begin
        if (lastDesc) begin
          doneStrobe = 1'b1; doneCode = EV_SUCCESS; stateD = S_IDLE;
        end else begin
          st.followBranch = 1'b1; stateD = S_FLAGS;
        end
      end
      default: stateD = S_IDLE;
    endcase

    // peripheral end while active overrides anything else this cycle
    if (stateQ != S_IDLE && perEnd) begin
      st         = '0;
      doneStrobe = 1'b1;
      doneCode   = EV_EARLY_END;
      stateD     = S_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          stateQ <= S_IDLE;
    else if (softRst) stateQ <= S_IDLE;
    else              stateQ <= stateD;
  end

  // R3: a memory request is held with a steady address until answered
  a_r3_req_hold: assert property (@(posedge clk) disable iff (rst)
    (memReq && !memAck && !softRst && !perEnd) |=> (memReq && $stable(memAddr)));

  // R4: an offered transmit byte stays put until taken
  a_r4_tx_hold: assert property (@(posedge clk) disable iff (rst)
    (txValid && !txReady && !softRst && !perEnd) |=> (txValid && $stable(txData)));

  // R10: peripheral end terminates an active chain on the next edge
  a_r10_early_stop: assert property (@(posedge clk) disable iff (rst)
    (busy && perEnd && !softRst) |=> !busy);

  // R5: receive writes never spill into neighbouring lanes
  a_r5_write_lane: assert property (@(posedge clk) disable iff (rst)
    (memReq && memWe) |-> ($countones(memBe) == 1 && memAddr[1:0] == 2'b00));

endmodule

// File: rtl/dma_chain_engine.sv
module dma_chain_engine
  import dma_chain_pkg::*;
#(
  parameter int AddrW  = 32,
  parameter int CountW = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfgWrEn,
  input  logic [2:0]        cfgAddr,
  input  logic [31:0]       cfgWrData,
  output logic [31:0]       cfgRdData,
  output logic              irq,
  output logic              memReq,
  output logic              memWe,
  output logic [AddrW-1:0]  memAddr,
  output logic [3:0]        memBe,
  output logic [31:0]       memWdata,
  input  logic [31:0]       memRdata,
  input  logic              memAck,
  input  logic              memErr,
  output logic              txValid,
  output logic [7:0]        txData,
  input  logic              txReady,
  input  logic              rxValid,
  input  logic [7:0]        rxData,
  output logic              rxReady,
  input  logic              perEnd
);

  dpStrobe_t        st;
  logic             busy, doneStrobe, startPulse, softRst, dirP2M;
  logic [3:0]       doneCode;
  logic [AddrW-1:0] descPtr, curDesc, bufAddr;
  logic             fmtOk, lastDesc, countZero, remainOne;
  logic [7:0]       byteLatch;

  dma_regs #(.AddrW(AddrW)) u_regs (
    .clk(clk), .rst(rst), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .cfgRdData(cfgRdData), .busy(busy),
    .doneStrobe(doneStrobe), .doneCode(doneCode), .startPulse(startPulse),
    .softRst(softRst), .dirP2M(dirP2M), .descPtr(descPtr), .irqOut(irq)
  );

  dma_datapath #(.AddrW(AddrW), .CountW(CountW)) u_dp (
    .clk(clk), .rst(rst), .st(st), .dirP2M(dirP2M), .descPtr(descPtr),
    .memRdata(memRdata), .rxData(rxData), .fmtOk(fmtOk), .lastDesc(lastDesc),
    .countZero(countZero), .remainOne(remainOne), .curDesc(curDesc),
    .bufAddr(bufAddr), .byteLatch(byteLatch)
  );

  dma_ctrl #(.AddrW(AddrW)) u_ctrl (
    .clk(clk), .rst(rst), .softRst(softRst), .startPulse(startPulse),
    .dirP2M(dirP2M), .memAck(memAck), .memErr(memErr), .txReady(txReady),
    .rxValid(rxValid), .perEnd(perEnd), .fmtOk(fmtOk), .lastDesc(lastDesc),
    .countZero(countZero), .remainOne(remainOne), .curDesc(curDesc),
    .bufAddr(bufAddr), .byteLatch(byteLatch), .busy(busy),
    .doneStrobe(doneStrobe), .doneCode(doneCode), .st(st), .memReq(memReq),
    .memWe(memWe), .memAddr(memAddr), .memBe(memBe), .memWdata(memWdata),
    .txValid(txValid), .txData(txData), .rxReady(rxReady)
  );

endmodule

// File: tb/tb_dma_chain_engine.sv
module tb_dma_chain_engine;

  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] A_CTRL = 3'd0, A_IEN = 3'd1, A_STS = 3'd2, A_DESC = 3'd3, A_CHAN = 3'd4;
  // vector: [15] receive direction, [14] zero-count middle descriptor, [11:8] descriptors, [7:0] bytes each
  localparam logic [15:0] VEC [5] = '{16'h0104, 16'h0305, 16'h4303, 16'h8206, 16'hC302};

  logic clk = 1'b0;
  logic rst;
  logic cfgWrEn;
  logic [2:0] cfgAddr;
  logic [31:0] cfgWrData, cfgRdData;
  logic irq, memReq, memWe, memAck, memErr;
  logic [31:0] memAddr, memWdata, memRdata;
  logic [3:0] memBe;
  logic txValid, txReady, rxValid, rxReady, perEnd;
  logic [7:0] txData, rxData;

  logic [31:0] mem [256];
  logic tbWrEn;
  logic [7:0] tbWrAddr;
  logic [31:0] tbWrData;
  logic [31:0] cyc;
  logic [1:0] txMode;
  logic rxOn, txClr, rxClr;
  logic [7:0] txLog [64];
  logic [31:0] txCnt;
  logic [7:0] rxSeq;
  int nChecks = 0;
  int nFails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_chain_engine dut (
    .clk(clk), .rst(rst), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .cfgWrData(cfgWrData),
    .cfgRdData(cfgRdData), .irq(irq), .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
    .memBe(memBe), .memWdata(memWdata), .memRdata(memRdata), .memAck(memAck),
    .memErr(memErr), .txValid(txValid), .txData(txData), .txReady(txReady),
    .rxValid(rxValid), .rxData(rxData), .rxReady(rxReady), .perEnd(perEnd)
  );

  function automatic logic [7:0] pat(input logic [31:0] a);
    return a[7:0] ^ 8'hA5;
  endfunction

  function automatic logic [7:0] getByte(input logic [31:0] a);
    logic [31:0] w;
    w = mem[a[9:2]];
    return w[8*a[1:0] +: 8];
  endfunction

  // memory model: answers one cycle after a request, errors on address bit 31
  always @(posedge clk) begin
    if (rst) begin
      for (int w = 0; w < 256; w++)
        mem[w] <= {pat(32'(4*w+3)), pat(32'(4*w+2)), pat(32'(4*w+1)), pat(32'(4*w))};
      memAck <= 1'b0; memErr <= 1'b0; memRdata <= '0;
    end else begin
      if (tbWrEn) mem[tbWrAddr] <= tbWrData;
      if (memReq && !memAck) begin
        memAck <= 1'b1;
        memErr <= memAddr[31];
        memRdata <= mem[memAddr[9:2]];
        if (memWe && !memAddr[31])
          for (int b = 0; b < 4; b++)
            if (memBe[b]) mem[memAddr[9:2]][8*b +: 8] <= memWdata[8*b +: 8];
      end else begin
        memAck <= 1'b0; memErr <= 1'b0;
      end
    end
  end

  always @(posedge clk) begin
    if (rst) cyc <= '0; else cyc <= cyc + 1;
  end
  assign txReady = (txMode == 2'd0) || (txMode == 2'd1 && cyc[0]);
  assign rxValid = rxOn && cyc[0];
  assign rxData  = rxSeq;

  always @(posedge clk) begin
    if (txClr) txCnt <= '0;
    else if (txValid && txReady) begin
      txLog[txCnt[5:0]] <= txData;
      txCnt <= txCnt + 1;
    end
  end
  always @(posedge clk) begin
    if (rxClr) rxSeq <= 8'h30;
    else if (rxValid && rxReady) rxSeq <= rxSeq + 8'd7;
  end

  task automatic chkEq(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); cfgWrEn = 1'b1; cfgAddr = a; cfgWrData = d;
    @(negedge clk); cfgWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); cfgAddr = a; #1; d = cfgRdData;
  endtask

  task automatic memPut(input logic [31:0] byteAddr, input logic [31:0] d);
    @(negedge clk); tbWrEn = 1'b1; tbWrAddr = byteAddr[9:2]; tbWrData = d;
    @(negedge clk); tbWrEn = 1'b0;
  endtask

  task automatic writeDesc(input logic [31:0] at, input logic [31:0] flags, input logic [31:0] buffer, input logic [31:0] nxt);
    memPut(at, flags); memPut(at + 4, buffer); memPut(at + 8, nxt);
  endtask

  task automatic clearLogs();
    @(negedge clk); txClr = 1'b1; rxClr = 1'b1;
    @(negedge clk); txClr = 1'b0; rxClr = 1'b0;
  endtask

  task automatic waitIdle(output logic [31:0] r);
    for (int t = 0; t < 3000; t++) begin
      regRead(A_CHAN, r);
      if (!r[7]) break;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks + 1, nFails + 1);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    rst = 1'b1; cfgWrEn = 1'b0; cfgAddr = '0; cfgWrData = '0; tbWrEn = 1'b0;
    tbWrAddr = '0; tbWrData = '0; txMode = 2'd0; rxOn = 1'b0; perEnd = 1'b0;
    txClr = 1'b1; rxClr = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0; txClr = 1'b0; rxClr = 1'b0;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      regRead(3'(a), rd); chkEq("R1", "register after reset", rd, 0);
    end
    chkEq("R1", "irq after reset", {31'd0, irq}, 0);

    // R2 enable read-back
    regWrite(A_CTRL, 32'h1); regRead(A_CTRL, rd); chkEq("R2", "enable readback", rd, 1);
    regWrite(A_IEN, 32'h1);

    // vector table walk
    for (int v = 0; v < 5; v++) begin
      logic dir, zm;
      int n, nb, k;
      dir = VEC[v][15]; zm = VEC[v][14]; n = int'(VEC[v][11:8]); nb = int'(VEC[v][7:0]);
      txMode = (v % 2 == 1) ? 2'd1 : 2'd0;
      clearLogs();
      for (int i = 0; i < n; i++) begin
        int cnt;
        cnt = (zm && i == 1) ? 0 : nb;
        writeDesc(32'h40 + 32*i,
                  32'h4000_0000 | 32'(cnt) | ((i == n-1) ? 32'h8000_0000 : 32'h0),
                  (dir ? 32'h301 : 32'h201) + 16*i, 32'h40 + 32*(i+1));
      end
      regWrite(A_DESC, 32'h40);
      rxOn = dir;
      regWrite(A_CHAN, (dir ? 32'h0040_0000 : 32'h0) | 32'h80);
      waitIdle(rd);
      rxOn = 1'b0;
      chkEq("R6", "success code", {28'd0, rd[3:0]}, 15);
      chkEq("R6", "run cleared", {31'd0, rd[7]}, 0);
      regRead(A_STS, rd); chkEq("R6", "status set", rd, 1);
      chkEq("R7", "irq raised", {31'd0, irq}, 1);
      k = 0;
      for (int i = 0; i < n; i++) begin
        int cnt;
        logic [31:0] b;
        cnt = (zm && i == 1) ? 0 : nb;
        b = (dir ? 32'h301 : 32'h201) + 16*i;
        for (int j = 0; j < cnt; j++) begin
          if (!dir) chkEq("R4", "tx byte order", {24'd0, txLog[k]}, {24'd0, pat(b + j)});
          else chkEq("R5", "rx byte stored", {24'd0, getByte(b + j)}, {24'd0, 8'(8'h30 + 7*k)});
          k++;
        end
        if (dir) chkEq("R5", "lane below untouched", {24'd0, getByte(b - 1)}, {24'd0, pat(b - 1)});
      end
      if (!dir) chkEq(zm ? "R13" : "R3", "bytes sent over chain", txCnt, 32'(k));
      else chkEq(zm ? "R13" : "R3", "bytes taken over chain", 32'(rxSeq), 32'(8'(8'h30 + 7*k)));
      regWrite(A_STS, 32'h1);
    end

    // R11 writes while busy are ignored
    writeDesc(32'h40, 32'hC000_0008, 32'h201, 32'h0);
    regWrite(A_DESC, 32'h40);
    clearLogs(); txMode = 2'd2;
    regWrite(A_CHAN, 32'h80);
    repeat (10) @(negedge clk);
    regWrite(A_CHAN, 32'h0040_0080);
    regRead(A_CHAN, rd);
    chkEq("R11", "direction held", {31'd0, rd[22]}, 0);
    chkEq("R11", "still running", {31'd0, rd[7]}, 1);
    txMode = 2'd0;
    waitIdle(rd);
    chkEq("R11", "completes as transmit", {28'd0, rd[3:0]}, 15);
    chkEq("R11", "transmit byte count", txCnt, 8);

    // R2 soft reset aborts (status left set from the previous chain)
    clearLogs(); txMode = 2'd2;
    regWrite(A_CHAN, 32'h80);
    repeat (10) @(negedge clk);
    regWrite(A_CTRL, 32'h101);
    regRead(A_CHAN, rd);
    chkEq("R2", "run after soft reset", {31'd0, rd[7]}, 0);
    chkEq("R2", "event after soft reset", {28'd0, rd[3:0]}, 0);
    regRead(A_STS, rd); chkEq("R2", "status after soft reset", rd, 0);
    regRead(A_CTRL, rd); chkEq("R2", "control readback", rd, 1);
    txMode = 2'd0;
    repeat (20) @(negedge clk);
    chkEq("R2", "no bytes after soft reset", txCnt, 0);

    // R8 format bit clear
    writeDesc(32'h40, 32'h8000_0004, 32'h201, 32'h0);
    clearLogs();
    regWrite(A_CHAN, 32'h80);
    waitIdle(rd);
    chkEq("R8", "format error code", {28'd0, rd[3:0]}, 3);
    chkEq("R8", "no data moved", txCnt, 0);
    regWrite(A_STS, 32'h1);

    // R9 descriptor fetch error, then data error
    regWrite(A_DESC, 32'h8000_0040);
    regWrite(A_CHAN, 32'h80);
    waitIdle(rd);
    chkEq("R9", "descriptor read error code", {28'd0, rd[3:0]}, 3);
    regRead(A_STS, rd); chkEq("R9", "status on fetch error", rd, 1);
    regWrite(A_STS, 32'h1);
    regWrite(A_DESC, 32'h40);
    writeDesc(32'h40, 32'hC000_0004, 32'h8000_0201, 32'h0);
    clearLogs();
    regWrite(A_CHAN, 32'h80);
    waitIdle(rd);
    chkEq("R9", "data error code", {28'd0, rd[3:0]}, 4);
    chkEq("R9", "no byte sent on data error", txCnt, 0);
    regWrite(A_STS, 32'h1);

    // R10 early end from peripheral
    writeDesc(32'h40, 32'hC000_0004, 32'h301, 32'h0);
    rxOn = 1'b0;
    regWrite(A_CHAN, 32'h0040_0080);
    repeat (10) @(negedge clk);
    perEnd = 1'b1; @(negedge clk); perEnd = 1'b0;
    waitIdle(rd);
    chkEq("R10", "early end code", {28'd0, rd[3:0]}, 5);
    regRead(A_STS, rd); chkEq("R10", "status on early end", rd, 1);
    regWrite(A_STS, 32'h1);

    // R12 run with enable clear
    regWrite(A_CTRL, 32'h0);
    writeDesc(32'h40, 32'hC000_0002, 32'h201, 32'h0);
    clearLogs();
    regWrite(A_CHAN, 32'h80);
    repeat (5) @(negedge clk);
    regRead(A_CHAN, rd); chkEq("R12", "run not set", {31'd0, rd[7]}, 0);
    regRead(A_STS, rd); chkEq("R12", "no completion", rd, 0);
    chkEq("R12", "no bytes", txCnt, 0);
    regWrite(A_CTRL, 32'h1);

    // R7 interrupt gating and write-one-to-clear
    regWrite(A_IEN, 32'h0);
    regWrite(A_CHAN, 32'h80);
    waitIdle(rd);
    regRead(A_STS, rd); chkEq("R7", "status set while masked", rd, 1);
    chkEq("R7", "irq masked", {31'd0, irq}, 0);
    regWrite(A_STS, 32'h0);
    regRead(A_STS, rd); chkEq("R7", "write zero keeps status", rd, 1);
    regWrite(A_IEN, 32'h1);
    @(negedge clk); chkEq("R7", "irq unmasked", {31'd0, irq}, 1);
    regWrite(A_STS, 32'h1);
    regRead(A_STS, rd); chkEq("R7", "write one clears", rd, 0);
    chkEq("R7", "irq after clear", {31'd0, irq}, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule